// File: doc/BRIEF.md
# Burst-Release Stream FIFO with Watermark Backpressure

This block sits on the write side of a stream-to-memory path. Upstream beats arrive on a valid-qualified stream and are stored in a FIFO whose capacity is a whole number of bursts. The memory side never sees a partial burst. A request is raised only once a full burst of beats is stored, and a grant starts the release of exactly one burst, one beat per cycle, in arrival order.

A programmable watermark, given in bursts, raises a backpressure flag early so the producer can stop before the store fills. The store does not stall the producer. A beat that arrives while the store is full is discarded. The discard sets a sticky overflow flag and advances a saturating drop counter. Parameters must keep one burst below 4096 bytes and at no more than 256 beats when the memory side is an AXI-style bus.

Top module: `burst_wm_fifo`

## Requirements
- R1: After reset the store is empty: `burst_req`, `out_valid`, `out_last` and `overflow` are 0 and `drop_cnt` is 0.
- R2: `almost_full` is 1 exactly when the stored word count is at least the effective watermark times BURST_LEN. The watermark is counted in bursts, so a watermark of 0 holds `almost_full` at 1.
- R3: A `wm_level` value of DEPTH_BURSTS or more is clamped to an effective watermark of DEPTH_BURSTS-1.
- R4: A beat with `in_valid`=1 is stored when fewer than DEPTH_BURSTS*BURST_LEN words are held. When the store is full, the beat is dropped and leaves the stored data unchanged.
- R5: `overflow` rises in the cycle after the first dropped beat and stays 1 until reset.
- R6: `drop_cnt` increases by one for each dropped beat and saturates at 2^DROP_W-1.
- R7: `burst_req` is 1 exactly when no burst is being released and at least BURST_LEN words are stored. Once raised, it holds until granted.
- R8: When `burst_gnt` and `burst_req` are both 1 at a clock edge, `out_valid` is 1 for exactly the next BURST_LEN cycles. `out_last` is 1 on the final one of these cycles, and `out_data` gives the oldest stored beats in arrival order.
- R9: `burst_gnt` while `burst_req` is 0 has no effect: no beats are released.
- R10: Beats keep being stored while a burst is being released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wm_level | input | LVL_W | Backpressure watermark in bursts |
| in_valid | input | 1 | Upstream beat present |
| in_data | input | DATA_W | Upstream beat |
| almost_full | output | 1 | Backpressure toward the producer |
| burst_req | output | 1 | One complete burst is ready |
| burst_gnt | input | 1 | Memory side accepts a burst |
| out_valid | output | 1 | Released beat present |
| out_data | output | DATA_W | Released beat |
| out_last | output | 1 | Final beat of a burst |
| overflow | output | 1 | Sticky: a beat was dropped |
| drop_cnt | output | DROP_W | Saturating count of dropped beats |

## Verification
The hardest state to reach is a completely full store that is still receiving beats while the watermark clamp is active. The drop counter must also be pushed past its saturation point in the same run. The stimulus withholds grants and streams more beats than the store holds, for every watermark from 0 up to values above the depth. With a narrow drop counter, the extra beats drive it into saturation. A long mixed phase then interleaves writes with grants, so releases overlap fresh writes, and some grants arrive while no request is pending.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;

  // Watermark actually used: never reaches the full depth.
  function automatic int unsigned eff_level(input int unsigned lvl,
                                            input int unsigned depth_b);
    return (lvl >= depth_b) ? depth_b - 1 : lvl;
  endfunction

  // Occupancy in words at which backpressure is raised.
  function automatic int unsigned thresh_words(input int unsigned lvl,
                                               input int unsigned depth_b,
                                               input int unsigned blen);
    return eff_level(lvl, depth_b) * blen;
  endfunction

endpackage

// File: rtl/bfifo_store.sv
module bfifo_store #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 64,
  localparam int PTR_W = $clog2(WORDS),
  localparam int CNT_W = $clog2(WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  occ
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [PTR_W-1:0]  wptr, rptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(WORDS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (wr_en) wptr <= bump(wptr);
      if (rd_en) rptr <= bump(rptr);
      case ({wr_en, rd_en})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign rd_data = mem[rptr];
endmodule

// File: rtl/bfifo_drain.sv
module bfifo_drain #(
  parameter int BURST_LEN = 16,
  parameter int CNT_W     = 7,
  localparam int BEAT_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] occ,
  input  logic             gnt,
  output logic             req,
  output logic             active,
  output logic             last
);
  logic [BEAT_W-1:0] beat;

  assign req    = !active && (occ >= CNT_W'(BURST_LEN));
  assign last   = active && (beat == BEAT_W'(BURST_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (active) begin
      beat <= beat + 1'b1;
      if (last) active <= 1'b0;
    end else if (req && gnt) begin
      active <= 1'b1;
      beat   <= '0;
    end
  end
endmodule

// File: rtl/bfifo_drop.sv
module bfifo_drop #(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drop_ev,
  output logic              overflow,
  output logic [DROP_W-1:0] drop_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflow <= 1'b0;
      drop_cnt <= '0;
    end else if (drop_ev) begin
      overflow <= 1'b1;
      if (drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/burst_wm_fifo.sv
module burst_wm_fifo #(
  parameter int DATA_W       = 32,
  parameter int BURST_LEN    = 16,
  parameter int DEPTH_BURSTS = 4,
  parameter int DROP_W       = 16,
  localparam int WORDS       = DEPTH_BURSTS * BURST_LEN,
  localparam int CNT_W       = $clog2(WORDS + 1),
  localparam int LVL_W       = $clog2(DEPTH_BURSTS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  wm_level,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              almost_full,
  output logic              burst_req,
  input  logic              burst_gnt,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              overflow,
  output logic [DROP_W-1:0] drop_cnt
);
  // Named internal events, brought out for the checker.
  logic [CNT_W-1:0] occ;
  logic [CNT_W-1:0] thresh;
  logic             full, wr_ev, drop_ev, rd_ev;

  assign thresh  = CNT_W'(bfifo_pkg::thresh_words(32'(wm_level), DEPTH_BURSTS, BURST_LEN));
  assign full    = (occ == CNT_W'(WORDS));
  assign wr_ev   = in_valid && !full;
  assign drop_ev = in_valid && full;
  assign rd_ev   = out_valid;

  assign almost_full = (occ >= thresh);

  bfifo_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_ev), .wr_data(in_data),
    .rd_en(rd_ev), .rd_data(out_data),
    .occ(occ)
  );

  bfifo_drain #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) u_drain (
    .clk(clk), .rst_n(rst_n),
    .occ(occ), .gnt(burst_gnt),
    .req(burst_req), .active(out_valid), .last(out_last)
  );

  bfifo_drop #(.DROP_W(DROP_W)) u_drop (
    .clk(clk), .rst_n(rst_n),
    .drop_ev(drop_ev),
    .overflow(overflow), .drop_cnt(drop_cnt)
  );
endmodule

// File: rtl/bfifo_checker.sv
module bfifo_checker #(
  parameter int BURST_LEN    = 16,
  parameter int DEPTH_BURSTS = 4,
  parameter int DROP_W       = 16,
  parameter int CNT_W        = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  occ,
  input logic [CNT_W-1:0]  thresh,
  input logic              drop_ev,
  input logic              burst_req,
  input logic              burst_gnt,
  input logic              out_valid,
  input logic              out_last,
  input logic              overflow,
  input logic [DROP_W-1:0] drop_cnt
);
  localparam int WORDS = DEPTH_BURSTS * BURST_LEN;

  a_r7_req_needs_burst: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> occ >= CNT_W'(BURST_LEN));
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req && !burst_gnt |=> burst_req);
  a_r8_grant_starts: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req && burst_gnt |=> out_valid && !burst_req);
  a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
  a_r9_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !(burst_req && burst_gnt) |=> !out_valid);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r4_drop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |-> occ == CNT_W'(WORDS));
  a_r6_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev && drop_cnt != '1 |=> drop_cnt == $past(drop_cnt) + 1'b1);
  a_r3_thresh_below_depth: assert property (@(posedge clk) disable iff (!rst_n)
    thresh < CNT_W'(WORDS));
endmodule

bind burst_wm_fifo bfifo_checker #(
  .BURST_LEN(BURST_LEN), .DEPTH_BURSTS(DEPTH_BURSTS),
  .DROP_W(DROP_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .occ(occ), .thresh(thresh), .drop_ev(drop_ev),
  .burst_req(burst_req), .burst_gnt(burst_gnt), .out_valid(out_valid),
  .out_last(out_last), .overflow(overflow), .drop_cnt(drop_cnt)
);

// File: tb/test_burst_wm_fifo.sv
module test_burst_wm_fifo;
  localparam int DW = 8, BL = 4, DB = 4, DRW = 3;
  localparam int WORDS = DB * BL;
  localparam int SAT = (1 << DRW) - 1;

  logic clk = 0, rst_n = 0;
  logic [2:0]    wm_level = '0;
  logic          in_valid = 0, burst_gnt = 0;
  logic [DW-1:0] in_data = '0;
  logic          almost_full, burst_req, out_valid, out_last, overflow;
  logic [DW-1:0] out_data;
  logic [DRW-1:0] drop_cnt;

  always #2.5 clk = ~clk;

  burst_wm_fifo #(.DATA_W(DW), .BURST_LEN(BL), .DEPTH_BURSTS(DB), .DROP_W(DRW)) i_burst_wm_fifo (
    .clk(clk), .rst_n(rst_n), .wm_level(wm_level), .in_valid(in_valid), .in_data(in_data),
    .almost_full(almost_full), .burst_req(burst_req), .burst_gnt(burst_gnt),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .overflow(overflow), .drop_cnt(drop_cnt));

  int checks = 0, fails = 0, cyc = 0;
  // Reference state
  logic [DW-1:0] q[$];
  bit m_drain = 0, m_ov = 0;
  int m_beat = 0, m_drops = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int thr(input int lvl);
    int e = (lvl >= DB) ? DB - 1 : lvl;  // R3 clamp
    return e * BL;
  endfunction

  task automatic compare();
    chk("R2/R3 almost_full", int'(almost_full), int'(q.size() >= thr(int'(wm_level))));
    chk("R7 burst_req", int'(burst_req), int'(!m_drain && q.size() >= BL));
    chk("R8/R9 out_valid", int'(out_valid), int'(m_drain));
    chk("R8 out_last", int'(out_last), int'(m_drain && m_beat == BL - 1));
    if (m_drain) chk("R8/R10 out_data order", int'(out_data), int'(q[0]));
    chk("R5 overflow", int'(overflow), int'(m_ov));
    chk("R6 drop_cnt", int'(drop_cnt), m_drops);
  endtask

  task automatic step(input bit v, input logic [DW-1:0] d, input bit g);
    int sz;
    bit full;
    compare();
    in_valid = v; in_data = d; burst_gnt = g;
    sz = q.size();
    full = (sz == WORDS);
    @(posedge clk);
    if (m_drain) void'(q.pop_front());
    if (v && !full) q.push_back(d);          // R4
    if (v && full) begin
      m_ov = 1;
      if (m_drops < SAT) m_drops++;
    end
    if (m_drain) begin
      if (m_beat == BL - 1) m_drain = 0;
      m_beat++;
    end else if (sz >= BL && g) begin
      m_drain = 1; m_beat = 0;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    in_valid = 0; burst_gnt = 0; rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    q.delete(); m_drain = 0; m_ov = 0; m_beat = 0; m_drops = 0;
    chk("R1 burst_req", int'(burst_req), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_last", int'(out_last), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 drop_cnt", int'(drop_cnt), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int lvl = 0; lvl < 8; lvl++) begin
      wm_level = 3'(lvl);
      do_reset();
      // R9: grant with too little stored
      step(1, 8'(lvl * 32), 1);
      step(1, 8'(lvl * 32 + 1), 1);
      // Fill past capacity, no grants: R2, R4, R5, R6
      for (int i = 2; i < WORDS + 10; i++) step(1, 8'(lvl * 32 + i), 0);
      // Drain all bursts while grants are offered: R7, R8
      for (int i = 0; i < 24; i++) step(0, '0, (i % 6) == 0);
      // Mixed traffic: R10
      for (int i = 0; i < 200; i++)
        step((i % 3) != 0, 8'(i * 7 + lvl), (i % 5) == 0 || (i % 11) == 3);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule